// File: doc/BRIEF.md
# Split-Word Host RAM Port

This block gives a host processor single-port access to a word-organised memory whose 24-bit words are divided unevenly into a 16-bit lower half and an 8-bit upper half. The host presents an address and a half-select bit, then pulses either an active-low read strobe or an active-low write strobe. The strobes are asynchronous to the block. A two-flop synchronizer brings each of them into the system clock domain, and the block detects their edges there.

When a strobe falls, the block captures the address and the half-select. A read returns the chosen half right-justified on the data bus and drives every bus bit above that half to zero. A write stores the low bits of the data bus into the chosen half when the write strobe rises and leaves the other half of the word as it was. The bidirectional bus is split into a data input, a data output and an output enable. The enable is asserted only while a read is in progress. If both strobes fall in the same cycle, the write is carried out and the read is dropped.

Top module: `split_word_ram_port`

## Requirements
- R1: With the half-select low (0) at capture, a read returns word bits 15:0 on data_o[15:0] and data_o[23:16] is 0.
- R2: With the half-select high (1) at capture, a read returns word bits 23:16 on data_o[7:0] and data_o[23:8] is 0.
- R3: A write with the half-select low stores data_i[15:0] into word bits 15:0. Word bits 23:16 keep their old value, and data_i[23:16] has no effect.
- R4: A write with the half-select high stores data_i[7:0] into word bits 23:16. Word bits 15:0 keep their old value, and data_i[23:8] has no effect.
- R5: The address and half-select are captured when a strobe's synchronized falling edge is seen. Changes to them while the strobe stays low do not affect that access.
- R6: Write data is taken from data_i when the synchronized rising edge of the write strobe is seen, not when the strobe falls.
- R7: If both strobes fall in the same cycle, the write is performed and the read is ignored: data_oe_o stays 0 for that access.
- R8: data_oe_o is 1 only while the synchronized read strobe is low during a read access. It is 0 once the strobe returns high. Read data is valid on data_o within 5 clock cycles of rd_n_i falling.
- R9: During and directly after reset, data_oe_o is 0 and data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address from the host |
| half_i | input | 1 | Half-select: 0 lower 16 bits, 1 upper 8 bits |
| rd_n_i | input | 1 | Asynchronous read strobe, active low |
| wr_n_i | input | 1 | Asynchronous write strobe, active low |
| data_i | input | LO_W+HI_W | Data bus input from the host |
| data_o | output | LO_W+HI_W | Data bus output toward the host |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
The bench builds the block with ADDR_W set to 6, which gives 64 words, and keeps the default 16/8 split, so every field position matches the default build. The small depth keeps uninitialised locations away from the test addresses. It also leaves room for the capture tests, which move the address to a second, separately preloaded word in the middle of an access, so that a capture at the wrong time shows up as a wrong value.

// File: rtl/swr_pkg.sv
package swr_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_i,
    output logic level_o,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_n_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
    assign rise_o  = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/half_split_mem.sv
module half_split_mem #(
    parameter int ADDR_W = 10,
    parameter int LO_W   = 16,
    parameter int HI_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   we_lo_i,
    input  logic                   we_hi_i,
    input  logic [LO_W-1:0]        wdata_i,
    output logic [LO_W+HI_W-1:0]   rdata_o
);
    localparam int W     = LO_W + HI_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [LO_W-1:0] lo_mem [DEPTH];
    logic [HI_W-1:0] hi_mem [DEPTH];
    logic [W-1:0]    rdata_q;

    always_ff @(posedge clk) begin
        if (we_lo_i) lo_mem[addr_i] <= wdata_i;
        if (we_hi_i) hi_mem[addr_i] <= wdata_i[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= {hi_mem[addr_i], lo_mem[addr_i]};
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/host_access_ctrl.sv
module host_access_ctrl
    import swr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LO_W   = 16,
    parameter int HI_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 half_i,
    input  logic                 rd_level_i,
    input  logic                 rd_fall_i,
    input  logic                 rd_rise_i,
    input  logic                 wr_fall_i,
    input  logic                 wr_rise_i,
    input  logic [LO_W+HI_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic                 we_lo_o,
    output logic                 we_hi_o,
    output logic [LO_W+HI_W-1:0] dout_o,
    output logic                 oe_o,
    output op_e                  op_o,
    output logic                 half_o
);
    localparam int W = LO_W + HI_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic              half;
        logic [W-1:0]      dout;
    } state_t;

    state_t state_d, state_q;
    logic   we_lo_d, we_hi_d;

    always_comb begin
        state_d = state_q;
        we_lo_d = 1'b0;
        we_hi_d = 1'b0;

        if (wr_fall_i) begin
            state_d.op   = OP_WR;
            state_d.addr = addr_i;
            state_d.half = half_i;
        end else if (rd_fall_i) begin
            state_d.op   = OP_RD;
            state_d.addr = addr_i;
            state_d.half = half_i;
        end

        if (state_q.op == OP_WR && wr_rise_i) begin
            we_lo_d    = ~state_q.half;
            we_hi_d    = state_q.half;
            state_d.op = OP_IDLE;
        end

        if (state_q.op == OP_RD) begin
            if (state_q.half)
                state_d.dout = {{(W-HI_W){1'b0}}, mem_rdata_i[W-1:LO_W]};
            else
                state_d.dout = {{(W-LO_W){1'b0}}, mem_rdata_i[LO_W-1:0]};
            if (rd_rise_i)
                state_d.op = OP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{op: OP_IDLE, addr: '0, half: 1'b0, dout: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_addr_o = state_q.addr;
    assign we_lo_o    = we_lo_d;
    assign we_hi_o    = we_hi_d;
    assign dout_o     = state_q.dout;
    assign oe_o       = ~rd_level_i & (state_q.op == OP_RD);
    assign op_o       = state_q.op;
    assign half_o     = state_q.half;
endmodule

// File: rtl/split_word_ram_port.sv
module split_word_ram_port
    import swr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LO_W        = 16,
    parameter int HI_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   half_i,
    input  logic                   rd_n_i,
    input  logic                   wr_n_i,
    input  logic [LO_W+HI_W-1:0]   data_i,
    output logic [LO_W+HI_W-1:0]   data_o,
    output logic                   data_oe_o
);
    localparam int W = LO_W + HI_W;

    logic              rd_level, rd_fall, rd_rise;
    logic              wr_level, wr_fall, wr_rise;
    logic [ADDR_W-1:0] mem_addr;
    logic              we_lo, we_hi;
    logic [W-1:0]      mem_rdata;
    op_e               op_q;
    logic              cap_half;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n_i(rd_n_i),
        .level_o(rd_level), .fall_o(rd_fall), .rise_o(rd_rise)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n_i(wr_n_i),
        .level_o(wr_level), .fall_o(wr_fall), .rise_o(wr_rise)
    );

    host_access_ctrl #(.ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .addr_i(addr_i), .half_i(half_i),
        .rd_level_i(rd_level), .rd_fall_i(rd_fall), .rd_rise_i(rd_rise),
        .wr_fall_i(wr_fall), .wr_rise_i(wr_rise),
        .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
        .we_lo_o(we_lo), .we_hi_o(we_hi),
        .dout_o(data_o), .oe_o(data_oe_o),
        .op_o(op_q), .half_o(cap_half)
    );

    half_split_mem #(.ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .addr_i(mem_addr),
        .we_lo_i(we_lo), .we_hi_i(we_hi),
        .wdata_i(data_i[LO_W-1:0]), .rdata_o(mem_rdata)
    );

    logic unused_wr_level;
    assign unused_wr_level = wr_level;
endmodule

// File: rtl/swr_checker.sv
module swr_checker
    import swr_pkg::*;
#(
    parameter int LO_W = 16,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_n_i,
    input logic                 wr_n_i,
    input logic [LO_W+HI_W-1:0] data_o,
    input logic                 data_oe_o,
    input logic                 we_lo,
    input logic                 we_hi,
    input logic                 rd_fall,
    input logic                 wr_fall,
    input op_e                  op_q,
    input logic                 cap_half
);
    localparam int W = LO_W + HI_W;

    AST_LOWER_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        data_o[W-1:LO_W] == '0); // R1

    AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o) && cap_half) |-> data_o[W-1:HI_W] == '0); // R2

    AST_SINGLE_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo || we_hi) |-> !(we_lo && we_hi)); // R3

    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo || we_hi) |-> ($past(wr_n_i, 2) && !$past(wr_n_i, 3))); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && wr_fall) |=> (op_q == OP_WR)); // R7

    AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !$past(rd_n_i, 2)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!data_oe_o && data_o == '0)); // R9
endmodule

bind split_word_ram_port swr_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .data_o(data_o), .data_oe_o(data_oe_o),
    .we_lo(we_lo), .we_hi(we_hi),
    .rd_fall(rd_fall), .wr_fall(wr_fall),
    .op_q(op_q), .cap_half(cap_half)
);

// File: tb/split_word_ram_port_test.sv
`timescale 1ns/1ps
module split_word_ram_port_test;
    localparam int ADDR_W = 6;
    localparam int W      = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              half = 1'b0;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [W-1:0]      din = '0;
    logic [W-1:0]      dout;
    logic              oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    split_word_ram_port #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .half_i(half),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .data_i(din),
        .data_o(dout), .data_oe_o(oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic h, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; half = h; din = d;
        wr_n = 1'b0;
        wait_cyc(6);
        wr_n = 1'b1;
        wait_cyc(6);
    endtask

    task automatic host_read(input logic [ADDR_W-1:0] a, input logic h, output logic [W-1:0] d);
        @(negedge clk);
        addr = a; half = h;
        rd_n = 1'b0;
        wait_cyc(6);
        d = dout;
        check("R8 oe during read", {23'd0, oe}, 24'd1);
        rd_n = 1'b1;
        wait_cyc(6);
        check("R8 oe after read", {23'd0, oe}, 24'd0);
    endtask

    task automatic t_reset();
        wait_cyc(1);
        check("R9 oe in reset", {23'd0, oe}, 24'd0);
        check("R9 data in reset", dout, 24'd0);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R9 oe after reset", {23'd0, oe}, 24'd0);
        check("R9 data after reset", dout, 24'd0);
    endtask

    task automatic t_halves();
        logic [W-1:0] r;
        host_write(6'd3, 1'b0, 24'hFFA5C3);
        host_write(6'd3, 1'b1, 24'hABCD5E);
        host_read(6'd3, 1'b0, r);
        check("R1 lower read", r, 24'h00A5C3);
        host_read(6'd3, 1'b1, r);
        check("R2 upper read", r, 24'h00005E);
        host_write(6'd3, 1'b0, 24'h991234);
        host_read(6'd3, 1'b1, r);
        check("R3 upper kept after lower write", r, 24'h00005E);
        host_read(6'd3, 1'b0, r);
        check("R3 lower written", r, 24'h001234);
        host_write(6'd3, 1'b1, 24'hFFFF77);
        host_read(6'd3, 1'b0, r);
        check("R4 lower kept after upper write", r, 24'h001234);
        host_read(6'd3, 1'b1, r);
        check("R4 upper written", r, 24'h000077);
    endtask

    task automatic t_capture();
        logic [W-1:0] r;
        host_write(6'd9, 1'b1, 24'h0000C8);
        host_write(6'd9, 1'b0, 24'h00BEEF);
        @(negedge clk);
        addr = 6'd3; half = 1'b0;
        rd_n = 1'b0;
        wait_cyc(4);
        addr = 6'd9; half = 1'b1;
        wait_cyc(4);
        check("R5 read uses captured address", dout, 24'h001234);
        rd_n = 1'b1;
        wait_cyc(6);
        host_write(6'd11, 1'b0, 24'h000000);
        @(negedge clk);
        addr = 6'd10; half = 1'b0; din = 24'h004455;
        wr_n = 1'b0;
        wait_cyc(4);
        addr = 6'd11; half = 1'b1;
        wait_cyc(2);
        wr_n = 1'b1;
        wait_cyc(6);
        host_read(6'd10, 1'b0, r);
        check("R5 write went to captured address", r, 24'h004455);
        host_read(6'd11, 1'b0, r);
        check("R5 other word untouched", r, 24'h000000);
    endtask

    task automatic t_wdata();
        logic [W-1:0] r;
        @(negedge clk);
        addr = 6'd20; half = 1'b0; din = 24'h001111;
        wr_n = 1'b0;
        wait_cyc(3);
        din = 24'h002222;
        wait_cyc(3);
        wr_n = 1'b1;
        wait_cyc(6);
        host_read(6'd20, 1'b0, r);
        check("R6 data taken at strobe rise", r, 24'h002222);
    endtask

    task automatic t_simul();
        logic [W-1:0] r;
        host_write(6'd21, 1'b0, 24'h000BAD);
        @(negedge clk);
        addr = 6'd21; half = 1'b0; din = 24'h004321;
        rd_n = 1'b0; wr_n = 1'b0;
        wait_cyc(3);
        check("R7 oe low on collision", {23'd0, oe}, 24'd0);
        wait_cyc(3);
        check("R7 oe still low on collision", {23'd0, oe}, 24'd0);
        wr_n = 1'b1;
        wait_cyc(3);
        check("R7 read ignored after write", {23'd0, oe}, 24'd0);
        rd_n = 1'b1;
        wait_cyc(6);
        host_read(6'd21, 1'b0, r);
        check("R7 write performed", r, 24'h004321);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        t_reset();
        t_halves();
        t_capture();
        t_wdata();
        t_simul();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        wait_cyc(100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule